// File: doc/BRIEF.md
# PRG Bank Override Latch

A small register block that sits next to a host memory mapper in a cartridge-style address decoder. The host mapper normally drives the upper program-ROM bank lines (A13 through A17). This block holds a bank number of its own. Whenever the CPU addresses the 8 KiB window where CPU A14 is 1 and A13 is 0, the block replaces the host's bank lines with that number. Outside the window the host's lines pass through unchanged.

The register is reached through a spare chip-select output of the host mapper combined with CPU address bit 2. The address is only partly decoded. A write strobe sampled on the rising system clock while the chip-select is low and A2 is 0 loads the low six data bits. Bits 0..3 select PRG A13..A16, bit 4 selects PRG A17, and bit 5 is stored but drives no output. The output multiplexer is purely combinational, so the override adds no cycle of latency to any program fetch. An active-low flag reports when the override window is selected.

Top module: `prg_window_override`

## Requirements
- R1: While rst_ni is low the bank register holds 0, so in the window prg_o reads 5'b00000.
- R2: A write is taken on a rising clk_i edge when cpu_wr_i=1, host_cs_ni=0 and cpu_addr_i[2]=0; the new bank appears on prg_o (in the window) right after that edge.
- R3: A write strobe with host_cs_ni=1 or with cpu_addr_i[2]=1 leaves the bank register unchanged.
- R4: In the window (cpu_addr_i[14]=1, cpu_addr_i[13]=0), prg_o[3:0] (PRG A13..A16, bit 0 = A13) equal register bits 3:0, loaded from cpu_data_i[3:0].
- R5: In the window, prg_o[4] (PRG A17) equals register bit 4, loaded from cpu_data_i[4].
- R6: Outside the window, prg_o equals host_prg_i (bit 0 = A13, bit 4 = A17) in the same cycle, with no clock in between.
- R7: win_active_no is 0 exactly when cpu_addr_i[14]=1 and cpu_addr_i[13]=0, and 1 otherwise.
- R8: cpu_data_i[5] is stored in the register but changes no output; cpu_data_i[7:6] are ignored.
- R9: Address bits other than 2, 13 and 14 (including A15) affect neither the write decode nor the window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock; writes are taken on its rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cpu_addr_i | input | 16 | CPU address bus |
| cpu_data_i | input | 8 | CPU data bus |
| cpu_wr_i | input | 1 | Write strobe, active high, one clock per write |
| host_cs_ni | input | 1 | Spare chip-select from the host mapper, active low |
| host_prg_i | input | 5 | Host mapper PRG A13..A17 (bit 0 = A13) |
| prg_o | output | 5 | Final PRG A13..A17 to the program ROM |
| win_active_no | output | 1 | Low while the override window is addressed |

## Verification
The assertions assume that the write strobe, chip-select, address and data are settled before each rising clock edge. They also assume no write is requested in the reset cycle, because the write checks compare the output against the data bus one cycle earlier. The bench changes every input on the falling edge and keeps cpu_wr_i low while reset is applied, so each write it makes is a single clean pulse that the checker can relate to its data.

// File: rtl/prg_ovr_pkg.sv
package prg_ovr_pkg;
  localparam int DEF_ADDR_W  = 16;
  localparam int DEF_DATA_W  = 8;
  localparam int DEF_REG_W   = 6;
  localparam int DEF_PRG_W   = 5;
  localparam int DEF_SEL_BIT = 2;
  localparam int DEF_WIN_SET = 14;  // must be 1 inside the window
  localparam int DEF_WIN_CLR = 13;  // must be 0 inside the window
endpackage

// File: rtl/prg_ovr_decode.sv
module prg_ovr_decode #(
  parameter int ADDR_W  = prg_ovr_pkg::DEF_ADDR_W,
  parameter int SEL_BIT = prg_ovr_pkg::DEF_SEL_BIT,
  parameter int WIN_SET = prg_ovr_pkg::DEF_WIN_SET,
  parameter int WIN_CLR = prg_ovr_pkg::DEF_WIN_CLR
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic              cs_ni,
  output logic              load_o,
  output logic              win_o
);
  always_comb begin
    load_o = wr_i & ~cs_ni & ~addr_i[SEL_BIT];
    win_o  = addr_i[WIN_SET] & ~addr_i[WIN_CLR];
  end
endmodule

// File: rtl/prg_ovr_reg.sv
module prg_ovr_reg #(
  parameter int REG_W = prg_ovr_pkg::DEF_REG_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [REG_W-1:0] d_i,
  output logic [REG_W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_o <= '0;
    else if (load_i) q_o <= d_i;
  end
endmodule

// File: rtl/prg_ovr_mux.sv
module prg_ovr_mux #(
  parameter int PRG_W = prg_ovr_pkg::DEF_PRG_W
) (
  input  logic             sel_i,
  input  logic [PRG_W-1:0] own_i,
  input  logic [PRG_W-1:0] host_i,
  output logic [PRG_W-1:0] out_o
);
  for (genvar b = 0; b < PRG_W; b++) begin : g_line
    assign out_o[b] = sel_i ? own_i[b] : host_i[b];
  end
endmodule

// File: rtl/prg_window_override.sv
module prg_window_override #(
  parameter int ADDR_W  = prg_ovr_pkg::DEF_ADDR_W,
  parameter int DATA_W  = prg_ovr_pkg::DEF_DATA_W,
  parameter int REG_W   = prg_ovr_pkg::DEF_REG_W,
  parameter int PRG_W   = prg_ovr_pkg::DEF_PRG_W,
  parameter int SEL_BIT = prg_ovr_pkg::DEF_SEL_BIT,
  parameter int WIN_SET = prg_ovr_pkg::DEF_WIN_SET,
  parameter int WIN_CLR = prg_ovr_pkg::DEF_WIN_CLR
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] cpu_addr_i,
  input  logic [DATA_W-1:0] cpu_data_i,
  input  logic              cpu_wr_i,
  input  logic              host_cs_ni,
  input  logic [PRG_W-1:0]  host_prg_i,
  output logic [PRG_W-1:0]  prg_o,
  output logic              win_active_no
);
  localparam int SPARE_W = REG_W - PRG_W;

  logic             load;
  logic             win;
  logic [REG_W-1:0] bank_q;

  // Partial decode: only the select bit and the two window bits matter.
  logic addr_unused;
  logic data_unused;
  logic spare_unused;
  assign addr_unused  = ^cpu_addr_i;
  assign data_unused  = ^cpu_data_i;
  assign spare_unused = ^bank_q[REG_W-1:PRG_W];

  prg_ovr_decode #(
    .ADDR_W (ADDR_W),
    .SEL_BIT(SEL_BIT),
    .WIN_SET(WIN_SET),
    .WIN_CLR(WIN_CLR)
  ) u_dec (
    .addr_i(cpu_addr_i),
    .wr_i  (cpu_wr_i),
    .cs_ni (host_cs_ni),
    .load_o(load),
    .win_o (win)
  );

  prg_ovr_reg #(.REG_W(REG_W)) u_reg (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(load),
    .d_i   (cpu_data_i[REG_W-1:0]),
    .q_o   (bank_q)
  );

  prg_ovr_mux #(.PRG_W(PRG_W)) u_mux (
    .sel_i (win),
    .own_i (bank_q[PRG_W-1:0]),
    .host_i(host_prg_i),
    .out_o (prg_o)
  );

  assign win_active_no = ~win;

  if (SPARE_W < 1) begin : g_bad_cfg
    initial $error("REG_W must exceed PRG_W");
  end
endmodule

// File: rtl/prg_window_override_chk.sv
module prg_window_override_chk #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int REG_W  = 6,
  parameter int PRG_W  = 5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] cpu_addr_i,
  input logic [DATA_W-1:0] cpu_data_i,
  input logic              cpu_wr_i,
  input logic              host_cs_ni,
  input logic [PRG_W-1:0]  host_prg_i,
  input logic [PRG_W-1:0]  prg_o,
  input logic              win_active_no,
  input logic [REG_W-1:0]  bank_q
);
  logic took;
  logic live;
  assign took = cpu_wr_i && !host_cs_ni && !cpu_addr_i[2];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) live <= 1'b0;
    else         live <= 1'b1;
  end

  p_reset_zero_r1: assert property (@(posedge clk_i) !rst_ni |-> bank_q == '0);

  p_write_take_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    live && $past(took) && !win_active_no |-> prg_o == $past(cpu_data_i[PRG_W-1:0]));

  p_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    live && !$past(took) && !$past(win_active_no) && !win_active_no |-> $stable(prg_o));

  p_host_pass_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_active_no |-> prg_o == host_prg_i);

  p_win_flag_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (win_active_no == 1'b0) == (cpu_addr_i[14] && !cpu_addr_i[13]));

  p_spare_store_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    live && $past(took) |-> bank_q[REG_W-1] == $past(cpu_data_i[REG_W-1]));
endmodule

bind prg_window_override prg_window_override_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .REG_W(REG_W), .PRG_W(PRG_W)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .cpu_addr_i   (cpu_addr_i),
  .cpu_data_i   (cpu_data_i),
  .cpu_wr_i     (cpu_wr_i),
  .host_cs_ni   (host_cs_ni),
  .host_prg_i   (host_prg_i),
  .prg_o        (prg_o),
  .win_active_no(win_active_no),
  .bank_q       (bank_q)
);

// File: tb/sim_prg_window_override.sv
module sim_prg_window_override;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] cpu_addr_i = 16'h0000;
  logic [7:0]  cpu_data_i = 8'h00;
  logic        cpu_wr_i = 1'b0;
  logic        host_cs_ni = 1'b1;
  logic [4:0]  host_prg_i = 5'h00;
  logic [4:0]  prg_o;
  logic        win_active_no;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  prg_window_override u0 (.*);

  localparam int NV = 14;
  localparam bit          V_WR  [NV] = '{0,0,1,0,0,1,0,1,0,1,0,0,1,0};
  localparam bit          V_CS  [NV] = '{1,1,0,1,1,0,1,1,1,0,1,1,0,1};
  localparam logic [15:0] V_AD  [NV] = '{16'hC000,16'h8000,16'h9C00,16'hC000,16'hE000,
                                         16'h9C04,16'hC123,16'h9C00,16'hDFFF,16'h1C03,
                                         16'hC000,16'h4000,16'hDC00,16'h2000};
  localparam logic [7:0]  V_DA  [NV] = '{8'h00,8'h00,8'h2A,8'h00,8'h00,8'h1F,8'h00,8'h15,
                                         8'h00,8'hD0,8'h00,8'h00,8'h00,8'h00};
  localparam logic [4:0]  V_HO  [NV] = '{5'h1F,5'h15,5'h03,5'h1F,5'h11,5'h00,5'h00,5'h07,
                                         5'h07,5'h02,5'h00,5'h0E,5'h19,5'h1B};
  localparam logic [4:0]  V_EP  [NV] = '{5'h00,5'h15,5'h03,5'h0A,5'h11,5'h00,5'h0A,5'h07,
                                         5'h0A,5'h02,5'h10,5'h10,5'h00,5'h1B};
  localparam bit          V_EW  [NV] = '{0,1,1,0,1,1,0,1,0,1,0,0,0,1};
  localparam string       V_TAG [NV] = '{"R1","R6","R2","R4 R8","R7","R3","R3 R9","R3",
                                         "R3","R9","R5","R9","R2","R7"};

  task automatic chk(input string tag, input logic [4:0] got, input logic [4:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic drive(input bit wr, input bit cs, input logic [15:0] a,
                       input logic [7:0] d, input logic [4:0] h);
    cpu_wr_i = wr; host_cs_ni = cs; cpu_addr_i = a; cpu_data_i = d; host_prg_i = h;
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    drive(0, 1, 16'hC000, 8'h00, 5'h1F);
    #1;
    chk("R1 reset window", prg_o, 5'h00);
    chk("R7 reset flag", {4'h0, win_active_no}, 5'h00);
    @(negedge clk_i);
    rst_ni = 1'b1;

    // vector table
    for (int i = 0; i < NV; i++) begin
      @(negedge clk_i);
      drive(V_WR[i], V_CS[i], V_AD[i], V_DA[i], V_HO[i]);
      @(posedge clk_i);
      #2;
      chk({V_TAG[i], " prg"}, prg_o, V_EP[i]);
      chk({V_TAG[i], " flag"}, {4'h0, win_active_no}, {4'h0, V_EW[i]});
    end

    // R6: pass-through with no clock edge
    @(negedge clk_i);
    drive(0, 1, 16'h8000, 8'h00, 5'h09);
    #1 chk("R6 comb a", prg_o, 5'h09);
    host_prg_i = 5'h16;
    #1 chk("R6 comb b", prg_o, 5'h16);
    cpu_addr_i = 16'hC000;
    #1 chk("R4 comb switch", prg_o, 5'h00);

    // R1: reset during operation
    @(negedge clk_i);
    drive(1, 0, 16'h9C00, 8'h3F, 5'h00);
    @(negedge clk_i);
    drive(0, 1, 16'hC000, 8'h00, 5'h04);
    #1 chk("R5 full bank", prg_o, 5'h1F);
    rst_ni = 1'b0;
    #1 chk("R1 async clear", prg_o, 5'h00);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    #1 chk("R1 after release", prg_o, 5'h00);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule